// File: doc/BRIEF.md
# Multi-lane SPI phase shifter

This block runs one serial flash transaction at a time. It shifts out a command byte, then a 3- or 4-byte address, then an optional run of dummy bytes, and then a data phase that either transmits or receives bytes. The data phase can be empty. The command byte always travels on one lane. A 3-bit interface-type code decides whether the address and data bytes are spread over 2 or 4 lanes. The block generates the serial clock and an output enable for each of the four IO lanes. It requests each byte to be transmitted, one at a time, and reports each received byte with a one-cycle strobe.

A transaction starts with a one-cycle `start` pulse while the block is idle. The whole configuration is captured on that cycle: code, address width, dummy count, command, address, length and direction. Chip-select timing is handled outside the block, and so is any register decoding.

Top module: `mlspi_phase_shifter`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `sclk`, `tx_req` and `rx_valid` are low, and `io_oe` and `io_out` are all zero.
- R2: The command byte goes out first. It is sent MSB first on lane 0 only, over 8 serial clocks, with `io_oe` = 4'b0001.
- R3: The address follows the command, MSB first. When `addr_4b` is 0, the block sends `addr[23:0]` as 3 bytes; when it is 1, it sends all 32 bits as 4 bytes. The address uses 2 lanes for code 2, 4 lanes for code 4 and 1 lane for every other code.
- R4: The data phase uses 1 lane for code 0, 2 lanes for codes 1 and 2, and 4 lanes for codes 3 and 4. A byte therefore takes 8, 4 or 2 serial clocks. On several lanes, the higher lane carries the more significant bit: with 2 lanes, bit 7 is on lane 1 and bit 6 on lane 0 in the first clock. Write data is driven with `io_oe` set on exactly the lanes in use.
- R5: Codes 5, 6 and 7 behave exactly as code 0.
- R6: After the address come `dummy_bytes` x 8 serial clocks. During them every `io_oe` bit is low and `io_out` is zero. A count of 0 skips the phase.
- R7: In a read data phase every `io_oe` bit is low. In single-lane mode the block samples lane 1; otherwise it samples the lanes in use. It samples on the rising serial clock edge. One cycle after the last rising edge of a byte, `rx_valid` pulses for one cycle with the byte on `rx_byte`.
- R8: In a write, `tx_req` is high for one cycle, the high half of the last serial clock of the preceding byte. The block captures `tx_byte` in that cycle, and that value is the next byte sent.
- R9: `sclk` idles low. Each serial clock lasts two system clocks, one low and one high. Lane values change only at the start of the low half.
- R10: One cycle after the final high half, `busy` falls and `done` pulses for one cycle. With `data_len` = 0 the transaction ends after the address or dummy phase.
- R11: A `start` pulse while `busy` is high is ignored, and the running transaction continues unchanged.
- R12: `io_out` is zero on every lane whose `io_oe` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| if_code | input | 3 | Interface type: 0 1-1-1, 1 1-1-2, 2 1-2-2, 3 1-1-4, 4 1-4-4 |
| addr_4b | input | 1 | 0 = 3-byte address, 1 = 4-byte address |
| dummy_bytes | input | 4 | Dummy length in bytes (8 serial clocks each) |
| cmd_byte | input | 8 | Command byte |
| addr | input | 32 | Flash address |
| data_len | input | 14 | Data byte count (0 allowed) |
| write_op | input | 1 | 1 = transmit data, 0 = receive data |
| tx_byte | input | 8 | Byte to transmit, sampled while tx_req is high |
| tx_req | output | 1 | Request for the next transmit byte |
| rx_valid | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| sclk | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
Some properties are checked on every cycle: the serial clock stays low while idle and its high half lasts exactly one cycle, disabled lanes never carry a one, and the enable pattern is always one of the legal lane masks. Also on every cycle, `done` and `rx_valid` are single-cycle pulses, `done` only appears while idle, and the captured interface code holds still through a transaction. Other behaviour can only be shown by the bench's scenarios, by comparing every cycle against a behavioural trace built from the configuration. This covers the lane and bit order in each phase, the 3- versus 4-byte address, the dummy length, the timing of the transmit request, the sampling lane for reads, the fallback of codes 5 to 7, the empty data phase and a rejected `start` mid-transaction.

// File: rtl/mlspi_pkg.sv
package mlspi_pkg;

  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_ADDR  = 3'd2,
    ST_DUMMY = 3'd3,
    ST_DATA  = 3'd4
  } seq_st_e;

  typedef enum logic [1:0] {
    LW_ONE  = 2'd0,
    LW_TWO  = 2'd1,
    LW_FOUR = 2'd2
  } lane_w_e;

  localparam logic [2:0] IF_STD      = 3'd0;
  localparam logic [2:0] IF_DUAL_OUT = 3'd1;
  localparam logic [2:0] IF_DUAL_IO  = 3'd2;
  localparam logic [2:0] IF_QUAD_OUT = 3'd3;
  localparam logic [2:0] IF_QUAD_IO  = 3'd4;

  function automatic logic [3:0] lane_mask(lane_w_e w);
    case (w)
      LW_TWO:  return 4'b0011;
      LW_FOUR: return 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic logic [2:0] last_beat(lane_w_e w);
    case (w)
      LW_TWO:  return 3'd3;
      LW_FOUR: return 3'd1;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/mlspi_lane_map.sv
module mlspi_lane_map
  import mlspi_pkg::*;
(
  input  logic [2:0] if_code,
  output lane_w_e    addr_w,
  output lane_w_e    data_w
);

  // Command is always single lane; this only widens address and data.
  always_comb begin
    addr_w = LW_ONE;
    data_w = LW_ONE;
    case (if_code)
      IF_DUAL_OUT: data_w = LW_TWO;
      IF_DUAL_IO: begin
        addr_w = LW_TWO;
        data_w = LW_TWO;
      end
      IF_QUAD_OUT: data_w = LW_FOUR;
      IF_QUAD_IO: begin
        addr_w = LW_FOUR;
        data_w = LW_FOUR;
      end
      default: ; // IF_STD and unused codes fall back to one lane
    endcase
  end

endmodule

// File: rtl/mlspi_tx_shift.sv
module mlspi_tx_shift
  import mlspi_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       load_val,
  input  logic             shift,
  input  lane_w_e          width,
  output logic [LANES-1:0] lanes
);

  logic [7:0] sh_q;
  logic [7:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      case (width)
        LW_TWO:  sh_d = {sh_q[5:0], 2'b00};
        LW_FOUR: sh_d = {sh_q[3:0], 4'b0000};
        default: sh_d = {sh_q[6:0], 1'b0};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load || shift) begin
      sh_q <= sh_d;
    end
  end

  // Most significant pending bits go to the highest lane in use.
  always_comb begin
    lanes = '0;
    case (width)
      LW_TWO:  lanes[1:0] = sh_q[7:6];
      LW_FOUR: lanes[3:0] = sh_q[7:4];
      default: lanes[0]   = sh_q[7];
    endcase
  end

endmodule

// File: rtl/mlspi_rx_shift.sv
module mlspi_rx_shift
  import mlspi_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             last,
  input  lane_w_e          width,
  input  logic [LANES-1:0] io_in,
  output logic             rx_valid,
  output logic [7:0]       rx_byte
);

  logic [7:0] acc_q;
  logic [7:0] acc_d;
  logic [7:0] byte_q;
  logic       vld_q;

  // Single-lane reads arrive on lane 1, as in full-duplex wiring.
  always_comb begin
    case (width)
      LW_TWO:  acc_d = {acc_q[5:0], io_in[1:0]};
      LW_FOUR: acc_d = {acc_q[3:0], io_in[3:0]};
      default: acc_d = {acc_q[6:0], io_in[1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= sample && last;
      if (sample) begin
        acc_q <= acc_d;
      end
      if (sample && last) begin
        byte_q <= acc_d;
      end
    end
  end

  assign rx_valid = vld_q;
  assign rx_byte  = byte_q;

  // R7
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/mlspi_seq.sv
module mlspi_seq
  import mlspi_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        if_code,
  input  logic              addr_4b,
  input  logic [3:0]        dummy_bytes,
  input  logic [7:0]        cmd_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              write_op,
  input  logic [7:0]        tx_byte,
  input  lane_w_e           addr_w,
  input  lane_w_e           data_w,
  output logic [2:0]        iface,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic [LANES-1:0]  io_oe,
  output logic              tx_req,
  output logic              ld,
  output logic [7:0]        ld_val,
  output logic              shift,
  output lane_w_e           cur_w,
  output logic              rx_sample,
  output logic              rx_last
);

  seq_st_e           st_q, st_d, st_after, next_st;
  logic              ph_q, ph_d;
  logic [2:0]        beat_q, beat_d;
  logic [LEN_W-1:0]  byte_q, byte_d, bytes_last, next_idx;
  logic              done_q, done_d;

  logic [2:0]        iface_q;
  logic              a4_q;
  logic [3:0]        dummy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              wr_q;

  logic              start_ok;
  logic              beat_end;
  logic              byte_end;
  logic              phase_end;
  logic [1:0]        addr_idx;
  logic [7:0]        addr_byte;

  assign start_ok = start && (st_q == ST_IDLE);

  // Width of the phase currently on the wire
  always_comb begin
    case (st_q)
      ST_ADDR: cur_w = addr_w;
      ST_DATA: cur_w = data_w;
      default: cur_w = LW_ONE;
    endcase
  end

  always_comb begin
    beat_end  = (st_q != ST_IDLE) && ph_q;
    byte_end  = beat_end && (beat_q == last_beat(cur_w));
    case (st_q)
      ST_ADDR:  bytes_last = a4_q ? LEN_W'(3) : LEN_W'(2);
      ST_DUMMY: bytes_last = LEN_W'(dummy_q) - LEN_W'(1);
      ST_DATA:  bytes_last = len_q - LEN_W'(1);
      default:  bytes_last = '0;
    endcase
    phase_end = byte_end && (byte_q == bytes_last);
  end

  // Phase that follows the current one once its last byte is out
  always_comb begin
    case (st_q)
      ST_CMD:  st_after = ST_ADDR;
      ST_ADDR: begin
        if (dummy_q != '0)       st_after = ST_DUMMY;
        else if (len_q != '0)    st_after = ST_DATA;
        else                     st_after = ST_IDLE;
      end
      ST_DUMMY: st_after = (len_q != '0) ? ST_DATA : ST_IDLE;
      default:  st_after = ST_IDLE;
    endcase
    next_st  = phase_end ? st_after : st_q;
    next_idx = phase_end ? '0 : (byte_q + LEN_W'(1));
  end

  // Address bytes leave most significant first
  always_comb begin
    addr_idx = (a4_q ? 2'd3 : 2'd2) - next_idx[1:0];
    case (addr_idx)
      2'd3:    addr_byte = addr_q[31:24];
      2'd2:    addr_byte = addr_q[23:16];
      2'd1:    addr_byte = addr_q[15:8];
      default: addr_byte = addr_q[7:0];
    endcase
  end

  always_comb begin
    tx_req = byte_end && wr_q && (next_st == ST_DATA);
    ld     = start_ok || byte_end;
    shift  = beat_end && !byte_end;
    if (start_ok) begin
      ld_val = cmd_byte;
    end else begin
      case (next_st)
        ST_ADDR: ld_val = addr_byte;
        ST_DATA: ld_val = wr_q ? tx_byte : 8'h00;
        default: ld_val = 8'h00;
      endcase
    end
    rx_sample = beat_end && (st_q == ST_DATA) && !wr_q;
    rx_last   = byte_end;
  end

  // Next-state process
  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    beat_d = beat_q;
    byte_d = byte_q;
    done_d = phase_end && (st_after == ST_IDLE);
    if (start_ok) begin
      st_d   = ST_CMD;
      ph_d   = 1'b0;
      beat_d = '0;
      byte_d = '0;
    end else if (st_q != ST_IDLE) begin
      ph_d = ~ph_q;
      if (beat_end) begin
        beat_d = byte_end ? 3'd0 : (beat_q + 3'd1);
        if (byte_end) begin
          byte_d = next_idx;
          st_d   = next_st;
        end
      end
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      beat_q <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      beat_q <= beat_d;
      byte_q <= byte_d;
      done_q <= done_d;
    end
  end

  // Configuration captured only when a transaction is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iface_q <= '0;
      a4_q    <= 1'b0;
      dummy_q <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wr_q    <= 1'b0;
    end else if (start_ok) begin
      iface_q <= if_code;
      a4_q    <= addr_4b;
      dummy_q <= dummy_bytes;
      addr_q  <= addr;
      len_q   <= data_len;
      wr_q    <= write_op;
    end
  end

  always_comb begin
    case (st_q)
      ST_CMD:  io_oe = LANES'(4'b0001);
      ST_ADDR: io_oe = LANES'(lane_mask(addr_w));
      ST_DATA: io_oe = wr_q ? LANES'(lane_mask(data_w)) : '0;
      default: io_oe = '0;
    endcase
  end

  assign iface = iface_q;
  assign busy  = (st_q != ST_IDLE);
  assign done  = done_q;
  assign sclk  = ph_q;

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_IDLE));

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> $stable(iface_q));

  // R8
  txreq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> ph_q);

endmodule

// File: rtl/mlspi_phase_shifter.sv
module mlspi_phase_shifter
  import mlspi_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        if_code,
  input  logic              addr_4b,
  input  logic [3:0]        dummy_bytes,
  input  logic [7:0]        cmd_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  data_len,
  input  logic              write_op,
  input  logic [7:0]        tx_byte,
  output logic              tx_req,
  output logic              rx_valid,
  output logic [7:0]        rx_byte,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  localparam int LANES = 4;

  logic [2:0] iface;
  lane_w_e    addr_w;
  lane_w_e    data_w;
  lane_w_e    cur_w;
  logic       ld;
  logic [7:0] ld_val;
  logic       shift;
  logic       rx_sample;
  logic       rx_last;

  mlspi_lane_map u_map (
    .if_code (iface),
    .addr_w  (addr_w),
    .data_w  (data_w)
  );

  mlspi_seq #(.LEN_W(LEN_W), .LANES(LANES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .if_code     (if_code),
    .addr_4b     (addr_4b),
    .dummy_bytes (dummy_bytes),
    .cmd_byte    (cmd_byte),
    .addr        (addr),
    .data_len    (data_len),
    .write_op    (write_op),
    .tx_byte     (tx_byte),
    .addr_w      (addr_w),
    .data_w      (data_w),
    .iface       (iface),
    .busy        (busy),
    .done        (done),
    .sclk        (sclk),
    .io_oe       (io_oe),
    .tx_req      (tx_req),
    .ld          (ld),
    .ld_val      (ld_val),
    .shift       (shift),
    .cur_w       (cur_w),
    .rx_sample   (rx_sample),
    .rx_last     (rx_last)
  );

  mlspi_tx_shift #(.LANES(LANES)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .shift    (shift),
    .width    (cur_w),
    .lanes    (io_out)
  );

  mlspi_rx_shift #(.LANES(LANES)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (rx_sample),
    .last     (rx_last),
    .width    (data_w),
    .io_in    (io_in),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte)
  );

  // R12
  lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_out & ~io_oe) == 4'b0000);

  // R9
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && io_oe == 4'b0000));

  // R9
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> !sclk);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  oe_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b0011) || (io_oe == 4'b1111));

endmodule

// File: tb/mlspi_phase_shifter_test.sv
module mlspi_phase_shifter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  if_code;
  logic        addr_4b;
  logic [3:0]  dummy_bytes;
  logic [7:0]  cmd_byte;
  logic [31:0] addr;
  logic [13:0] data_len;
  logic        write_op;
  logic [7:0]  tx_byte;
  logic        tx_req;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        busy;
  logic        done;
  logic        sclk;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic [3:0]  io_in;

  always #5 clk = ~clk;

  mlspi_phase_shifter uut (
    .clk(clk), .rst_n(rst_n), .start(start), .if_code(if_code),
    .addr_4b(addr_4b), .dummy_bytes(dummy_bytes), .cmd_byte(cmd_byte),
    .addr(addr), .data_len(data_len), .write_op(write_op),
    .tx_byte(tx_byte), .tx_req(tx_req), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .busy(busy), .done(done), .sclk(sclk),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  typedef struct packed {
    logic       sclk;
    logic       busy;
    logic       done;
    logic       txr;
    logic       rxv;
    logic [7:0] rxb;
    logic [3:0] oe;
    logic [3:0] io;
    logic [3:0] drv;
  } ent_t;

  ent_t       q[$];
  string      tq[$];
  int         checks = 0;
  int         errors = 0;
  bit         pend;
  logic [7:0] pend_b;
  logic [7:0] wdata[16];
  logic [7:0] rdata[16];
  bit         finished = 0;

  function automatic int addr_lanes(input logic [2:0] c);
    if (c == 3'd2) return 2;
    if (c == 3'd4) return 4;
    return 1;
  endfunction

  function automatic int data_lanes(input logic [2:0] c);
    if (c == 3'd1 || c == 3'd2) return 2;
    if (c == 3'd3 || c == 3'd4) return 4;
    return 1;
  endfunction

  function automatic logic [3:0] wmask(input int w);
    return 4'((1 << w) - 1);
  endfunction

  task automatic push(input ent_t e, input string t);
    ent_t x;
    x = e;
    if (pend) begin
      x.rxv = 1'b1;
      x.rxb = pend_b;
      pend  = 0;
    end
    q.push_back(x);
    tq.push_back(t);
  endtask

  // One byte on the wire: two system clocks per serial clock, low half first
  task automatic add_byte(input int w, input logic [7:0] v, input logic [3:0] oe,
                          input bit rd, input logic [7:0] rv, input string t);
    for (int i = 0; i < 8 / w; i++) begin
      int   sh;
      int   vi;
      int   ri;
      ent_t e;
      sh = 8 - w * (i + 1);
      vi = int'(v);
      ri = int'(rv);
      e = '0;
      e.busy = 1'b1;
      e.oe   = oe;
      e.io   = 4'((vi >> sh) & ((1 << w) - 1));
      if (rd) begin
        if (w == 1) e.drv = {2'b00, 1'(ri >> sh), 1'b0};
        else        e.drv = 4'((ri >> sh) & ((1 << w) - 1));
      end
      push(e, t);
      e.sclk = 1'b1;
      push(e, t);
    end
    if (rd) begin
      pend   = 1;
      pend_b = rv;
    end
  endtask

  task automatic build(input logic [2:0] c, input bit a4, input logic [3:0] dum,
                       input logic [7:0] cmd, input logic [31:0] ad, input int len,
                       input bit wr, input string ovr);
    int   al;
    int   dl;
    int   nb;
    ent_t e;
    q.delete();
    tq.delete();
    pend = 0;
    al = addr_lanes(c);
    dl = data_lanes(c);
    nb = a4 ? 4 : 3;
    add_byte(1, cmd, 4'b0001, 0, 8'h00, (ovr != "") ? ovr : "R2");
    for (int k = 0; k < nb; k++)
      add_byte(al, 8'(ad >> (8 * (nb - 1 - k))), wmask(al), 0, 8'h00, (ovr != "") ? ovr : "R3");
    for (int d = 0; d < int'(dum); d++)
      add_byte(1, 8'h00, 4'b0000, 0, 8'h00, (ovr != "") ? ovr : "R6");
    for (int k = 0; k < len; k++) begin
      if (wr) begin
        q[q.size() - 1].txr = 1'b1;
        add_byte(dl, wdata[k], wmask(dl), 0, 8'h00, (ovr != "") ? ovr : "R4");
      end else begin
        add_byte(dl, 8'h00, 4'b0000, 1, rdata[k], (ovr != "") ? ovr : "R7");
      end
    end
    e = '0;
    e.done = 1'b1;
    push(e, "R10");
    e.done = 1'b0;
    push(e, "R10");
    push(e, "R10");
  endtask

  task automatic cmp(input ent_t e, input string t);
    logic [24:0] act;
    logic [24:0] exp;
    string       tag;
    act = {sclk, busy, done, tx_req, rx_valid, (e.rxv ? rx_byte : 8'h00), io_oe, io_out};
    exp = {e.sclk, e.busy, e.done, e.txr, e.rxv, e.rxb, e.oe, e.io};
    checks++;
    if (act !== exp) begin
      if (sclk !== e.sclk)                               tag = "R9";
      else if (tx_req !== e.txr)                         tag = "R8";
      else if (rx_valid !== e.rxv || act[15:8] !== e.rxb) tag = "R7";
      else if (busy !== e.busy || done !== e.done)       tag = "R10";
      else                                               tag = t;
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
    // R12: disabled lanes stay low
    checks++;
    if ((io_out & ~io_oe) !== 4'b0000) begin
      errors++;
      $display("FAIL R12 t=%0t actual io_out=%b io_oe=%b expected masked zero",
               $time, io_out, io_oe);
    end
  endtask

  task automatic run_op(input logic [2:0] c, input bit a4, input logic [3:0] dum,
                        input logic [7:0] cmd, input logic [31:0] ad, input int len,
                        input bit wr, input string ovr, input bit inject);
    int  k;
    bit  adv;
    build(c, a4, dum, cmd, ad, len, wr, ovr);
    @(negedge clk);
    if_code     = c;
    addr_4b     = a4;
    dummy_bytes = dum;
    cmd_byte    = cmd;
    addr        = ad;
    data_len    = 14'(len);
    write_op    = wr;
    k           = 0;
    tx_byte     = wdata[0];
    start       = 1'b1;
    @(negedge clk);
    start = 1'b0;
    adv   = 0;
    for (int j = 0; j < q.size(); j++) begin
      if (j > 0) @(negedge clk);
      if (adv) begin
        k++;
        tx_byte = wdata[k];
        adv = 0;
      end
      cmp(q[j], tq[j]);
      io_in = q[j].drv;
      if (q[j].txr) adv = 1;
      // R11: a start pulse with different settings while busy
      if (inject) begin
        if (j == 6) begin
          start    = 1'b1;
          cmd_byte = 8'h3C;
          if_code  = 3'd4;
          addr     = ~ad;
          write_op = ~wr;
        end else if (j == 7) begin
          start = 1'b0;
        end
      end
    end
    io_in = 4'b0000;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual still running, expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n       = 1'b0;
    start       = 1'b0;
    if_code     = 3'd0;
    addr_4b     = 1'b0;
    dummy_bytes = 4'd0;
    cmd_byte    = 8'h00;
    addr        = 32'h0;
    data_len    = 14'd0;
    write_op    = 1'b0;
    tx_byte     = 8'h00;
    io_in       = 4'b0000;
    for (int i = 0; i < 16; i++) begin
      wdata[i] = 8'(8'hC3 ^ (i * 29));
      rdata[i] = 8'(8'h5A + (i * 71));
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    checks++;
    if ({busy, done, sclk, tx_req, rx_valid, io_oe, io_out} !== 13'b0) begin
      errors++;
      $display("FAIL R1 actual=%b expected=0",
               {busy, done, sclk, tx_req, rx_valid, io_oe, io_out});
    end

    // R2 R3 R7: standard read, 3-byte address, read sampled on lane 1
    run_op(3'd0, 1'b0, 4'd0, 8'h03, 32'hFF12_3456, 2, 1'b0, "", 1'b0);
    // R3 R4 R6 R8: standard write, 4-byte address, one dummy byte
    run_op(3'd0, 1'b1, 4'd1, 8'h12, 32'h89AB_CDEF, 2, 1'b1, "", 1'b0);
    // R4 R7: dual output read
    run_op(3'd1, 1'b0, 4'd1, 8'h3B, 32'h0001_8000, 3, 1'b0, "", 1'b0);
    // R3 R4 R6: dual IO read with 4-byte address and two dummy bytes
    run_op(3'd2, 1'b1, 4'd2, 8'hBB, 32'hA5C3_0F96, 2, 1'b0, "", 1'b0);
    // R4 R8: quad output write
    run_op(3'd3, 1'b0, 4'd0, 8'h32, 32'h0070_0001, 3, 1'b1, "", 1'b0);
    // R3 R4 R7: quad IO read
    run_op(3'd4, 1'b1, 4'd1, 8'hEC, 32'h1357_9BDF, 4, 1'b0, "", 1'b0);
    // R3 R4 R8: quad IO write
    run_op(3'd4, 1'b0, 4'd0, 8'h38, 32'h0024_6801, 2, 1'b1, "", 1'b0);
    // R5: unused codes behave as standard
    run_op(3'd6, 1'b0, 4'd1, 8'h0B, 32'h00AB_CDEF, 1, 1'b0, "R5", 1'b0);
    run_op(3'd7, 1'b1, 4'd0, 8'h02, 32'hDEAD_BEEF, 1, 1'b1, "R5", 1'b0);
    run_op(3'd5, 1'b0, 4'd0, 8'h05, 32'h0000_0000, 1, 1'b0, "R5", 1'b0);
    // R10: empty data phase ends after the address
    run_op(3'd2, 1'b0, 4'd0, 8'h20, 32'h0055_AA00, 0, 1'b0, "R10", 1'b0);
    // R10 R6: empty data phase ends after dummy bytes
    run_op(3'd0, 1'b0, 4'd3, 8'h4B, 32'h0000_0100, 0, 1'b0, "R10", 1'b0);
    // R11: start while busy is ignored
    run_op(3'd1, 1'b0, 4'd0, 8'h02, 32'h0012_3400, 2, 1'b1, "R11", 1'b1);
    // R4: dual IO write of a single byte
    run_op(3'd2, 1'b0, 4'd0, 8'h02, 32'h00FE_DCBA, 1, 1'b1, "", 1'b0);

    summary();
    $finish;
  end

endmodule